// File: doc/BRIEF.md
# Fuse Array Burst Read Controller

This block sits between a simple register bus and a one-time-programmable fuse macro of 1024 bytes. Software first programs a configuration word with two timing counts: a setup adjust and a strobe width. It then writes a command word that holds a start byte address, a byte count minus one and a read request. The controller visits the requested bytes one at a time. For each byte it drives an access-enable and an address for a setup window, then raises a read strobe and captures the returned byte at the end of the strobe window. The bytes are packed into eight 32-bit data words, and a completion flag is raised.

The flag can be polled, or it can raise an interrupt output. The command word also carries burn-related request bits. These are stored and read back, but any command carrying them makes no fuse access. The fuse array is organised as seven consecutive segments of 64, 128, 128, 3520, 8, 2296 and 2048 bits. Software reaches any of them through the byte address.

Top module: `efuse_rd_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x0 (command), 0x4 (timing), 0x8 (status) and 0xC+4n for data word n = 0..7. All of them read zero after reset, and any other offset reads zero.
- R2: The timing register keeps interrupt enable at bit 31, read setup adjust at [23:20], read strobe width at [19:16], burn adjust at [15:12] and burn strobe at [11:0]. Bits [30:24] read zero.
- R3: The command register holds the byte address at [30:21], the length minus one at [20:16], the program request at bit 15, the write request at bit 1 and the read request at bit 0. An idle write with bit 0 set and bits 1 and 15 clear starts a read of length+1 bytes from the byte address. Byte addresses wrap modulo 1024.
- R4: Each byte access keeps fuse_en high for adjust+5+strobe cycles. fuse_strobe is low for the first adjust+1 of those cycles and high for the rest. Accesses follow each other with no gap, and the address is stable for the whole access.
- R5: Byte k of a burst lands in bits [8(k mod 4)+7 : 8(k mod 4)] of data word k/4. Bytes beyond the burst length read zero.
- R6: Status bit 0 is cleared when a read starts and set on the cycle after the last byte's strobe ends. Writing 1 to it clears it. Status bit 1 always reads zero.
- R7: Command bit 0 reads 1 while a burst is in progress and returns to 0 by itself when the burst ends.
- R8: A command with bit 1 or bit 15 set makes no fuse access and changes neither status nor data words.
- R9: A command written while a burst is in progress is ignored. The burst in progress continues unchanged, and the command fields keep their values.
- R10: irq is high exactly when status bit 0 and the interrupt enable are both set. It falls when software clears bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| fuse_en | output | 1 | Fuse macro access enable |
| fuse_strobe | output | 1 | Fuse macro read strobe |
| fuse_addr | output | 10 | Fuse byte address |
| fuse_rdata | input | 8 | Fuse read data, valid while the strobe is high |
| irq | output | 1 | Read-complete interrupt |

## Verification
The bench checks the strobe window on every cycle of a burst, with the smallest and the largest timing counts. An off-by-one in either counter would shift the strobe edge or stretch the access. It reads the data words after a short burst and after one that wraps past the last byte address. A design that failed to clear stale bytes, or that carried the address into an eleventh bit, would show there. A command during a busy burst and commands carrying burn requests are also applied. A design that restarted, re-targeted, or touched the fuse or the done flag on those commands would be caught at fuse_en, fuse_addr, status and the data words.

// File: rtl/efuse_rd_pkg.sv
package efuse_rd_pkg;
  // command word field positions
  localparam int CMD_RD_BIT    = 0;
  localparam int CMD_WR_BIT    = 1;
  localparam int CMD_PG_BIT    = 15;
  localparam int CMD_LEN_LSB   = 16;
  localparam int CMD_ADDR_LSB  = 21;
  // timing word field positions
  localparam int TIM_WSTB_LSB  = 0;
  localparam int TIM_WADJ_LSB  = 12;
  localparam int TIM_RSTB_LSB  = 16;
  localparam int TIM_RADJ_LSB  = 20;
  localparam int TIM_IRQ_BIT   = 31;
  // status bit
  localparam int STS_DONE_BIT  = 0;
  // register word indices
  localparam logic [3:0] WIDX_CMD   = 4'd0;
  localparam logic [3:0] WIDX_TIM   = 4'd1;
  localparam logic [3:0] WIDX_STS   = 4'd2;
  localparam logic [3:0] WIDX_DATA0 = 4'd3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2
  } phase_t;
endpackage

// File: rtl/efuse_phase_timer.sv
module efuse_phase_timer
  import efuse_rd_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [TW-1:0] adj,
  input  logic [TW-1:0] stb,
  output logic          in_setup,
  output logic          in_strobe,
  output logic          last
);
  localparam int CW = TW + 2;

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] stb_end;

  assign stb_end   = CW'(stb) + CW'(3);
  assign in_setup  = (ph_q == PH_SETUP);
  assign in_strobe = (ph_q == PH_STROBE);
  assign last      = in_strobe && (cnt_q == stb_end);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (go) begin
          ph_d  = PH_SETUP;
          cnt_d = '0;
        end
      end
      PH_SETUP: begin
        if (cnt_q == CW'(adj)) begin
          ph_d  = PH_STROBE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_STROBE: begin
        if (last) begin
          ph_d  = go ? PH_SETUP : PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/efuse_burst_seq.sv
module efuse_burst_seq #(
  parameter int AW = 10,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic          last,
  output logic          busy,
  output logic          go,
  output logic          capture,
  output logic          done,
  output logic [LW-1:0] idx,
  output logic [AW-1:0] fuse_addr
);
  logic          busy_q, busy_d;
  logic [LW-1:0] idx_q, idx_d;
  logic          final_byte;

  assign final_byte = (idx_q == len);
  assign capture    = last && busy_q;
  assign done       = capture && final_byte;
  assign go         = start || (capture && !final_byte);
  assign busy       = busy_q;
  assign idx        = idx_q;
  assign fuse_addr  = base + AW'(idx_q);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (capture) begin
      idx_d  = idx_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end
endmodule

// File: rtl/efuse_data_buf.sv
module efuse_data_buf #(
  parameter int NB = 32,
  parameter int LW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            capture,
  input  logic [LW-1:0]   idx,
  input  logic [7:0]      din,
  output logic [NB*8-1:0] flat
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] byte_q, byte_d;
    logic       byte_en;

    assign byte_en = clear || (capture && (idx == LW'(b)));
    assign byte_d  = clear ? 8'h00 : din;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= 8'h00;
      end else if (byte_en) begin
        byte_q <= byte_d;
      end
    end

    assign flat[8*b +: 8] = byte_q;
  end
endmodule

// File: rtl/efuse_rd_ctrl.sv
module efuse_rd_ctrl
  import efuse_rd_pkg::*;
#(
  parameter int FUSE_AW     = 10,
  parameter int BURST_BYTES = 32,
  parameter int TIM_W       = 4,
  parameter int WSTB_W      = 12,
  parameter int BUS_AW      = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               fuse_en,
  output logic               fuse_strobe,
  output logic [FUSE_AW-1:0] fuse_addr,
  input  logic [7:0]         fuse_rdata,
  output logic               irq
);
  localparam int LEN_W = $clog2(BURST_BYTES);
  localparam int NW    = BURST_BYTES / 4;
  localparam int WSEL  = $clog2(NW);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  // register state
  logic [FUSE_AW-1:0] cmd_addr_q;
  logic [LEN_W-1:0]   cmd_len_q;
  logic               cmd_pg_q, cmd_wr_q;
  logic               tim_irq_q;
  logic [TIM_W-1:0]   tim_radj_q, tim_rstb_q, tim_wadj_q;
  logic [WSTB_W-1:0]  tim_wstb_q;
  logic [TIM_W-1:0]   run_adj_q, run_stb_q;
  logic               rd_done_q, rd_done_d;

  // bus decode
  logic [3:0] widx;
  logic       wr_cmd, wr_tim, wr_sts, cmd_take, start;
  logic       busy, go, capture, done, last, in_setup, in_strobe;
  logic [LEN_W-1:0] idx;

  assign widx     = 4'(bus_addr[BUS_AW-1:2]);
  assign wr_cmd   = bus_we && (widx == WIDX_CMD);
  assign wr_tim   = bus_we && (widx == WIDX_TIM);
  assign wr_sts   = bus_we && (widx == WIDX_STS);
  assign cmd_take = wr_cmd && !busy;
  assign start    = cmd_take && bus_wdata[CMD_RD_BIT]
                    && !bus_wdata[CMD_WR_BIT] && !bus_wdata[CMD_PG_BIT];

  always_comb begin
    rd_done_d = rd_done_q;
    if (start)
      rd_done_d = 1'b0;
    else if (done)
      rd_done_d = 1'b1;
    else if (wr_sts && bus_wdata[STS_DONE_BIT])
      rd_done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      cmd_addr_q <= '0;
      cmd_len_q  <= '0;
      cmd_pg_q   <= 1'b0;
      cmd_wr_q   <= 1'b0;
    end else if (cmd_take) begin
      cmd_addr_q <= bus_wdata[CMD_ADDR_LSB +: FUSE_AW];
      cmd_len_q  <= bus_wdata[CMD_LEN_LSB +: LEN_W];
      cmd_pg_q   <= bus_wdata[CMD_PG_BIT];
      cmd_wr_q   <= bus_wdata[CMD_WR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      tim_irq_q  <= 1'b0;
      tim_radj_q <= '0;
      tim_rstb_q <= '0;
      tim_wadj_q <= '0;
      tim_wstb_q <= '0;
    end else if (wr_tim) begin
      tim_irq_q  <= bus_wdata[TIM_IRQ_BIT];
      tim_radj_q <= bus_wdata[TIM_RADJ_LSB +: TIM_W];
      tim_rstb_q <= bus_wdata[TIM_RSTB_LSB +: TIM_W];
      tim_wadj_q <= bus_wdata[TIM_WADJ_LSB +: TIM_W];
      tim_wstb_q <= bus_wdata[TIM_WSTB_LSB +: WSTB_W];
    end
  end

  // timing counts are frozen for the duration of a burst
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      run_adj_q <= '0;
      run_stb_q <= '0;
    end else if (start) begin
      run_adj_q <= tim_radj_q;
      run_stb_q <= tim_rstb_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)
      rd_done_q <= 1'b0;
    else
      rd_done_q <= rd_done_d;
  end

  efuse_phase_timer #(.TW(TIM_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .go        (go),
    .adj       (run_adj_q),
    .stb       (run_stb_q),
    .in_setup  (in_setup),
    .in_strobe (in_strobe),
    .last      (last)
  );

  efuse_burst_seq #(.AW(FUSE_AW), .LW(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .start     (start),
    .base      (cmd_addr_q),
    .len       (cmd_len_q),
    .last      (last),
    .busy      (busy),
    .go        (go),
    .capture   (capture),
    .done      (done),
    .idx       (idx),
    .fuse_addr (fuse_addr)
  );

  logic [NW-1:0][31:0] data_words;

  efuse_data_buf #(.NB(BURST_BYTES), .LW(LEN_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .clear   (start),
    .capture (capture),
    .idx     (idx),
    .din     (fuse_rdata),
    .flat    (data_words)
  );

  assign fuse_en     = in_setup || in_strobe;
  assign fuse_strobe = in_strobe;
  assign irq         = rd_done_q && tim_irq_q;

  // read mux
  logic [3:0] dw;
  assign dw = widx - WIDX_DATA0;

  always_comb begin
    bus_rdata = '0;
    if (widx == WIDX_CMD) begin
      bus_rdata[CMD_ADDR_LSB +: FUSE_AW] = cmd_addr_q;
      bus_rdata[CMD_LEN_LSB +: LEN_W]    = cmd_len_q;
      bus_rdata[CMD_PG_BIT]              = cmd_pg_q;
      bus_rdata[CMD_WR_BIT]              = cmd_wr_q;
      bus_rdata[CMD_RD_BIT]              = busy;
    end else if (widx == WIDX_TIM) begin
      bus_rdata[TIM_IRQ_BIT]              = tim_irq_q;
      bus_rdata[TIM_RADJ_LSB +: TIM_W]    = tim_radj_q;
      bus_rdata[TIM_RSTB_LSB +: TIM_W]    = tim_rstb_q;
      bus_rdata[TIM_WADJ_LSB +: TIM_W]    = tim_wadj_q;
      bus_rdata[TIM_WSTB_LSB +: WSTB_W]   = tim_wstb_q;
    end else if (widx == WIDX_STS) begin
      bus_rdata[STS_DONE_BIT] = rd_done_q;
    end else if ((widx >= WIDX_DATA0) && (32'(widx) < 32'(WIDX_DATA0) + NW)) begin
      bus_rdata = data_words[dw[WSEL-1:0]];
    end
  end
endmodule

// File: rtl/efuse_rd_ctrl_chk.sv
module efuse_rd_ctrl_chk #(
  parameter int FUSE_AW = 10,
  parameter int BUS_AW  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fuse_en,
  input logic               fuse_strobe,
  input logic [FUSE_AW-1:0] fuse_addr,
  input logic               irq,
  input logic               rd_done,
  input logic               busy,
  input logic               bus_we,
  input logic [BUS_AW-1:0]  bus_addr,
  input logic [31:0]        bus_wdata
);
  logic burn_cmd;
  assign burn_cmd = bus_we && (bus_addr[BUS_AW-1:2] == '0)
                    && (bus_wdata[1] || bus_wdata[15]) && !busy;

  assert_strobe_inside_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_strobe |-> fuse_en);

  assert_addr_held_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_strobe && $past(fuse_strobe)) |-> $stable(fuse_addr));

  assert_done_follows_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_done) |-> ($past(fuse_strobe) && !fuse_en));

  assert_busy_means_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> fuse_en);

  assert_burn_cmd_no_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burn_cmd |=> !fuse_en);

  assert_irq_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_done);
endmodule

bind efuse_rd_ctrl efuse_rd_ctrl_chk #(.FUSE_AW(FUSE_AW), .BUS_AW(BUS_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .fuse_en     (fuse_en),
  .fuse_strobe (fuse_strobe),
  .fuse_addr   (fuse_addr),
  .irq         (irq),
  .rd_done     (rd_done_q),
  .busy        (busy),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata)
);

// File: tb/efuse_rd_ctrl_test.sv
`timescale 1ns/1ps
module efuse_rd_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fuse_en, fuse_strobe, irq;
  logic [9:0]  fuse_addr;
  logic [7:0]  fuse_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom(int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  // behavioural fuse array: data only while strobed
  assign fuse_rdata = fuse_strobe ? rom(int'(fuse_addr)) : 8'h00;

  efuse_rd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_en(fuse_en),
    .fuse_strobe(fuse_strobe), .fuse_addr(fuse_addr), .fuse_rdata(fuse_rdata),
    .irq(irq)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_word(int base, int n, int w);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++) begin
      int k = 4 * w + j;
      if (k < n) r[8*j +: 8] = rom((base + k) % 1024);
    end
    return r;
  endfunction

  task automatic check_data(int base, int n, string req);
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      bus_read(6'(12 + 4 * w), d);
      check(d == exp_word(base, n, w), req, d, exp_word(base, n, w));
    end
  endtask

  // full burst with cycle-by-cycle comparison against the timing model
  task automatic run_burst(int base, int n, int adj, int stb, bit ie);
    int t = adj + 5 + stb;
    logic [31:0] d;
    bus_write(6'h04, {ie, 7'd0, 4'(adj), 4'(stb), 16'h0000});
    bus_write(6'h00, {1'b0, 10'(base), 5'(n - 1), 16'h0001});
    for (int b = 0; b < n; b++) begin
      for (int p = 0; p < t; p++) begin
        check(fuse_en == 1'b1, "R4 access enable", 32'(fuse_en), 32'd1);
        check(fuse_strobe == (p > adj), "R4 strobe window", 32'(fuse_strobe), 32'(p > adj));
        check(fuse_addr == 10'((base + b) % 1024), "R3 byte address", 32'(fuse_addr), 32'((base + b) % 1024));
        check(irq == 1'b0, "R10 irq low while busy", 32'(irq), 32'd0);
        if (b == 0 && p == 1) begin
          bus_read(6'h00, d);
          check(d[0] == 1'b1, "R7 busy bit set", 32'(d[0]), 32'd1);
          bus_read(6'h08, d);
          check(d == 32'd0, "R6 done cleared on start", d, 32'd0);
        end
        @(negedge clk);
      end
    end
    check(fuse_en == 1'b0, "R4 access ends", 32'(fuse_en), 32'd0);
    bus_read(6'h08, d);
    check(d == 32'd1, "R6 done set, bit1 zero", d, 32'd1);
    bus_read(6'h00, d);
    check(d[0] == 1'b0, "R7 busy bit self-clears", 32'(d[0]), 32'd0);
    check(irq == ie, "R10 irq follows enable", 32'(irq), 32'(ie));
    check_data(base, n, "R5 data packing");
  endtask

  task automatic burn_cmd(logic [31:0] cmd, int base, int n, string req);
    logic [31:0] d;
    bus_write(6'h00, cmd);
    for (int c = 0; c < 30; c++) begin
      check(fuse_en == 1'b0, req, 32'(fuse_en), 32'd0);
      @(negedge clk);
    end
    bus_read(6'h08, d);
    check(d == 32'd1, req, d, 32'd1);
    check_data(base, n, req);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int w = 0; w < 12; w++) begin
      bus_read(6'(4 * w), d);
      check(d == 32'd0, "R1 reset/unmapped reads zero", d, 32'd0);
    end
    check(fuse_en == 1'b0 && irq == 1'b0, "R1 outputs idle", {fuse_en, irq}, 32'd0);

    // R2 timing register fields
    bus_write(6'h04, 32'hFFFF_FFFF);
    bus_read(6'h04, d);
    check(d == 32'h80FF_FFFF, "R2 timing readback", d, 32'h80FF_FFFF);
    bus_write(6'h04, 32'h0035_A123);
    bus_read(6'h04, d);
    check(d == 32'h0035_A123, "R2 timing readback", d, 32'h0035_A123);

    // R3/R4/R5 full burst, shortest timing
    run_burst(0, 32, 0, 0, 1'b0);
    // short burst, unused bytes zero
    run_burst(100, 5, 2, 3, 1'b0);
    // wrap past top of array
    run_burst(1020, 8, 1, 0, 1'b0);
    // longest timing, single byte, interrupt on
    run_burst(517, 1, 15, 15, 1'b1);
    // R10 clear by writing 1 to status bit 0
    bus_write(6'h08, 32'h0000_0001);
    check(irq == 1'b0, "R10 irq clears", 32'(irq), 32'd0);
    bus_read(6'h08, d);
    check(d == 32'd0, "R6 done write-one-clear", d, 32'd0);

    run_burst(200, 6, 1, 1, 1'b0);
    // R8 burn requests make no access
    burn_cmd({1'b0, 10'd300, 5'd3, 16'h0003}, 200, 6, "R8 write request ignored");
    bus_read(6'h00, d);
    check(d == {1'b0, 10'd300, 5'd3, 16'h0002}, "R3 command readback", d, {1'b0, 10'd300, 5'd3, 16'h0002});
    burn_cmd({1'b0, 10'd301, 5'd3, 16'h8001}, 200, 6, "R8 program request ignored");

    // R9 command during busy burst
    bus_write(6'h04, {8'd0, 4'd1, 4'd0, 16'h0000});
    bus_write(6'h00, {1'b0, 10'd40, 5'd3, 16'h0001});
    repeat (4) @(negedge clk);
    bus_write(6'h00, {1'b0, 10'd700, 5'd0, 16'h0001});
    bus_read(6'h00, d);
    check(d[30:21] == 10'd40 && d[20:16] == 5'd3, "R9 fields kept while busy", d, {1'b0, 10'd40, 5'd3, 16'h0001});
    check(fuse_addr != 10'd700, "R9 burst not retargeted", 32'(fuse_addr), 32'd40);
    for (int c = 0; c < 200 && fuse_en; c++) @(negedge clk);
    bus_read(6'h08, d);
    check(d == 32'd1, "R9 burst completes", d, 32'd1);
    check_data(40, 4, "R9 data from first command");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule